// File: doc/BRIEF.md
# Indexed multi-stack operand file

This block holds the operand storage of a two-operand, multi-threaded processor. Every hardware thread owns a private set of small LIFO data stacks. An instruction names two of those stacks with short index fields. The block presents the top entry of each named stack as an operand. Each operand also carries a pop bit. When the pop bit is set, that top entry is consumed at the clock edge. When it is clear, the stack is left untouched. A result can be pushed onto any stack of the same thread in the same cycle.

Entries below the top can never be read, so the index fields stay narrow. Misuse of a stack pointer does not corrupt the stack. It raises a sticky per-stack fault flag instead, and the flag holds until the thread clears it. The ALU, instruction decode and memory access sit outside this block.

The thread, the indexes, the pop bits and the push controls are applied together for one cycle. The operand values are combinational reads of the state held before the edge. All pointer and data updates take effect at the rising edge.

Top module: `osf_operand_file`

## Requirements
- R1: There are NTHREADS (default 8) threads, each with NSTACKS (default 8) stacks. An operation under thread `thr` changes neither the contents nor the flags of any stack belonging to another thread.
- R2: `top_a` and `top_b` show, without a clock edge, the top entry of stack `idx_a` and stack `idx_b` of thread `thr`. An empty stack reads as zero, and equal indexes give equal values.
- R3: A read with its pop bit clear leaves the stack's contents and depth unchanged.
- R4: A read with its pop bit set removes the top entry at the rising edge, which exposes the entry below it.
- R5: When `push_en` is high, `push_data` is written to stack `push_idx` of thread `thr` at the rising edge and becomes its top entry.
- R6: A pop of an empty stack leaves its depth at zero and sets bit `s` of `uflow`, where `s` is the stack index.
- R7: A push onto a stack that holds DEPTH (default 4) entries discards the data, leaves the stack unchanged and sets bit `s` of `oflow`.
- R8: A pop and a push to the same stack in one cycle replace the top entry and keep the depth, with no overflow even when the stack is full. If the stack was empty, underflow is flagged and the pushed value becomes its only entry.
- R9: When both indexes name the same stack and both pop bits are set, that stack loses one entry, not two.
- R10: Bit `s` of `uflow` and `oflow` belongs to stack `s` of the selected thread. The bits are sticky. `flag_clr` clears every flag of thread `thr` at the edge, and a fault raised in that same cycle still sets its flag.
- R11: While `rst_n` is low (active low, asynchronous), every stack becomes empty and every flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| thr | input | log2(NTHREADS) | Selected thread |
| idx_a | input | log2(NSTACKS) | First operand stack index |
| pop_a | input | 1 | Consume the first operand |
| idx_b | input | log2(NSTACKS) | Second operand stack index |
| pop_b | input | 1 | Consume the second operand |
| push_en | input | 1 | Push a result this cycle |
| push_idx | input | log2(NSTACKS) | Stack that receives the result |
| push_data | input | WIDTH | Result value |
| flag_clr | input | 1 | Clear the fault flags of thread `thr` |
| top_a | output | WIDTH | Top entry of stack `idx_a` |
| top_b | output | WIDTH | Top entry of stack `idx_b` |
| uflow | output | NSTACKS | Sticky underflow flags of thread `thr` |
| oflow | output | NSTACKS | Sticky overflow flags of thread `thr` |

## Verification
The assertions assume that every control input is driven to a known value after reset. They also compare two cycles only when `thr` is the same in both, because the flags and operand outputs show a different thread whenever `thr` changes. The directed part of the stimulus holds one thread over each sequence of push, pop, fill and clear steps so that those comparisons apply. The random part draws only legal index and thread values, and each cycle's expectation comes from the bench's own stack model.

// File: rtl/osf_pkg.sv
package osf_pkg;

    // Operation applied to one stack in one cycle; bit 1 = push, bit 0 = pop.
    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_REPL = 2'b11
    } stk_op_e;

endpackage

// File: rtl/osf_op_decode.sv
module osf_op_decode
    import osf_pkg::*;
#(
    parameter int TW   = 3,
    parameter int IW   = 3,
    parameter int T_ID = 0,
    parameter int S_ID = 0
) (
    input  logic [TW-1:0] thr,
    input  logic [IW-1:0] idx_a,
    input  logic          pop_a,
    input  logic [IW-1:0] idx_b,
    input  logic          pop_b,
    input  logic          push_en,
    input  logic [IW-1:0] push_idx,
    input  logic          flag_clr,
    output stk_op_e       op,
    output logic          clr
);

    logic mine;
    logic want_pop;
    logic want_push;

    always_comb begin
        mine      = (thr == TW'(T_ID));
        // Two pops naming this stack still count as one (R9).
        want_pop  = mine && ((pop_a && idx_a == IW'(S_ID)) ||
                             (pop_b && idx_b == IW'(S_ID)));
        want_push = mine && push_en && (push_idx == IW'(S_ID));
        clr       = mine && flag_clr;
    end

    always_comb begin
        unique case ({want_push, want_pop})
            2'b00:   op = OP_HOLD;
            2'b01:   op = OP_POP;
            2'b10:   op = OP_PUSH;
            2'b11:   op = OP_REPL;
            default: op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/osf_stack.sv
module osf_stack
    import osf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_op_e          op,
    input  logic [WIDTH-1:0] wdata,
    input  logic             clr,
    output logic [WIDTH-1:0] top,
    output logic             uf,
    output logic             of
);

    localparam int CNTW = $clog2(DEPTH + 1);
    localparam int AW   = $clog2(DEPTH);

    logic [WIDTH-1:0] ent [DEPTH];
    logic [CNTW-1:0]  count;
    logic [CNTW-1:0]  nxt_count;
    logic [AW-1:0]    slot;
    logic [AW-1:0]    top_slot;
    logic             we;
    logic             uf_ev;
    logic             of_ev;
    logic             empty;
    logic             full;

    always_comb begin
        empty    = (count == '0);
        full     = (count == CNTW'(DEPTH));
        top_slot = AW'(count - CNTW'(1));
    end

    // Next-state decision for this stack.
    always_comb begin
        nxt_count = count;
        we        = 1'b0;
        slot      = AW'(count);
        uf_ev     = 1'b0;
        of_ev     = 1'b0;
        unique case (op)
            OP_HOLD: ;
            OP_POP: begin
                if (empty) uf_ev = 1'b1;
                else       nxt_count = count - CNTW'(1);
            end
            OP_PUSH: begin
                if (full) begin
                    of_ev = 1'b1;
                end else begin
                    we        = 1'b1;
                    nxt_count = count + CNTW'(1);
                end
            end
            OP_REPL: begin
                we = 1'b1;
                if (empty) begin
                    uf_ev     = 1'b1;
                    slot      = '0;
                    nxt_count = CNTW'(1);
                end else begin
                    slot = top_slot;
                end
            end
            default: ;
        endcase
    end

    // State register: depth and sticky flags.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            uf    <= 1'b0;
            of    <= 1'b0;
        end else begin
            count <= nxt_count;
            if (uf_ev)    uf <= 1'b1;
            else if (clr) uf <= 1'b0;
            if (of_ev)    of <= 1'b1;
            else if (clr) of <= 1'b0;
        end
    end

    // Entry storage carries no reset; depth guards every read.
    always_ff @(posedge clk) begin
        if (we) ent[slot] <= wdata;
    end

    always_comb begin
        top = empty ? '0 : ent[top_slot];
    end

endmodule

// File: rtl/osf_read_port.sv
module osf_read_port #(
    parameter int TW     = 3,
    parameter int IW     = 3,
    parameter int WIDTH  = 32,
    parameter int NCELLS = 64
) (
    input  logic [TW-1:0]    thr,
    input  logic [IW-1:0]    idx,
    input  logic [WIDTH-1:0] cells [NCELLS],
    output logic [WIDTH-1:0] data
);

    logic [TW+IW-1:0] sel;

    always_comb begin
        sel  = {thr, idx};
        data = cells[sel];
    end

endmodule

// File: rtl/osf_operand_file.sv
module osf_operand_file
    import osf_pkg::*;
#(
    parameter int NTHREADS = 8,
    parameter int NSTACKS  = 8,
    parameter int DEPTH    = 4,
    parameter int WIDTH    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(NTHREADS)-1:0] thr,
    input  logic [$clog2(NSTACKS)-1:0]  idx_a,
    input  logic                       pop_a,
    input  logic [$clog2(NSTACKS)-1:0]  idx_b,
    input  logic                       pop_b,
    input  logic                       push_en,
    input  logic [$clog2(NSTACKS)-1:0]  push_idx,
    input  logic [WIDTH-1:0]           push_data,
    input  logic                       flag_clr,
    output logic [WIDTH-1:0]           top_a,
    output logic [WIDTH-1:0]           top_b,
    output logic [NSTACKS-1:0]         uflow,
    output logic [NSTACKS-1:0]         oflow
);

    // NTHREADS and NSTACKS are powers of two; DEPTH is at least 2.
    localparam int TW     = $clog2(NTHREADS);
    localparam int IW     = $clog2(NSTACKS);
    localparam int NCELLS = NTHREADS * NSTACKS;

    logic [WIDTH-1:0]  cell_top [NCELLS];
    logic [NCELLS-1:0] cell_uf;
    logic [NCELLS-1:0] cell_of;

    for (genvar g = 0; g < NCELLS; g++) begin : g_cell
        stk_op_e op;
        logic    clr_here;

        osf_op_decode #(
            .TW  (TW),
            .IW  (IW),
            .T_ID(g / NSTACKS),
            .S_ID(g % NSTACKS)
        ) u_dec (
            .thr     (thr),
            .idx_a   (idx_a),
            .pop_a   (pop_a),
            .idx_b   (idx_b),
            .pop_b   (pop_b),
            .push_en (push_en),
            .push_idx(push_idx),
            .flag_clr(flag_clr),
            .op      (op),
            .clr     (clr_here)
        );

        osf_stack #(
            .DEPTH(DEPTH),
            .WIDTH(WIDTH)
        ) u_stk (
            .clk  (clk),
            .rst_n(rst_n),
            .op   (op),
            .wdata(push_data),
            .clr  (clr_here),
            .top  (cell_top[g]),
            .uf   (cell_uf[g]),
            .of   (cell_of[g])
        );
    end

    osf_read_port #(
        .TW(TW), .IW(IW), .WIDTH(WIDTH), .NCELLS(NCELLS)
    ) u_rd_a (
        .thr  (thr),
        .idx  (idx_a),
        .cells(cell_top),
        .data (top_a)
    );

    osf_read_port #(
        .TW(TW), .IW(IW), .WIDTH(WIDTH), .NCELLS(NCELLS)
    ) u_rd_b (
        .thr  (thr),
        .idx  (idx_b),
        .cells(cell_top),
        .data (top_b)
    );

    always_comb begin
        for (int s = 0; s < NSTACKS; s++) begin
            uflow[s] = cell_uf[{thr, IW'(s)}];
            oflow[s] = cell_of[{thr, IW'(s)}];
        end
    end

endmodule

// File: rtl/osf_operand_file_chk.sv
module osf_operand_file_chk #(
    parameter int NTHREADS = 8,
    parameter int NSTACKS  = 8,
    parameter int DEPTH    = 4,
    parameter int WIDTH    = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [$clog2(NTHREADS)-1:0] thr,
    input logic [$clog2(NSTACKS)-1:0]  idx_a,
    input logic                       pop_a,
    input logic [$clog2(NSTACKS)-1:0]  idx_b,
    input logic                       pop_b,
    input logic                       push_en,
    input logic [$clog2(NSTACKS)-1:0]  push_idx,
    input logic [WIDTH-1:0]           push_data,
    input logic                       flag_clr,
    input logic [WIDTH-1:0]           top_a,
    input logic [WIDTH-1:0]           top_b,
    input logic [NSTACKS-1:0]         uflow,
    input logic [NSTACKS-1:0]         oflow
);

    localparam int TW = $clog2(NTHREADS);
    localparam int IW = $clog2(NSTACKS);

    logic               past_ok;
    logic [TW-1:0]      p_thr;
    logic [IW-1:0]      p_push_idx;
    logic               p_push_en;
    logic               p_clr;
    logic [WIDTH-1:0]   p_data;
    logic [NSTACKS-1:0] p_uf;
    logic [NSTACKS-1:0] p_of;
    logic [NSTACKS-1:0] p_popmask;
    logic [NSTACKS-1:0] popmask;
    logic [NSTACKS-1:0] pushmask;
    logic [NSTACKS-1:0] p_pushmask;

    always_comb begin
        popmask = '0;
        if (pop_a) popmask[idx_a] = 1'b1;
        if (pop_b) popmask[idx_b] = 1'b1;
        pushmask = '0;
        if (push_en) pushmask[push_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok    <= 1'b0;
            p_thr      <= '0;
            p_push_idx <= '0;
            p_push_en  <= 1'b0;
            p_clr      <= 1'b0;
            p_data     <= '0;
            p_uf       <= '0;
            p_of       <= '0;
            p_popmask  <= '0;
            p_pushmask <= '0;
        end else begin
            past_ok    <= 1'b1;
            p_thr      <= thr;
            p_push_idx <= push_idx;
            p_push_en  <= push_en;
            p_clr      <= flag_clr;
            p_data     <= push_data;
            p_uf       <= uflow;
            p_of       <= oflow;
            p_popmask  <= popmask;
            p_pushmask <= pushmask;
        end
    end

    // R10
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && thr == p_thr && !p_clr) |->
            (((uflow & p_uf) == p_uf) && ((oflow & p_of) == p_of)));

    // R6
    uflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && thr == p_thr) |-> ((uflow & ~p_uf & ~p_popmask) == '0));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && thr == p_thr) |->
            ((oflow & ~p_of & ~(p_pushmask & ~p_popmask)) == '0));

    // R5
    push_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && thr == p_thr && p_push_en && idx_a == p_push_idx &&
         !oflow[p_push_idx]) |-> (top_a == p_data));

    // R2
    same_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_a == idx_b) |-> (top_a == top_b));

endmodule

bind osf_operand_file osf_operand_file_chk #(
    .NTHREADS(NTHREADS),
    .NSTACKS (NSTACKS),
    .DEPTH   (DEPTH),
    .WIDTH   (WIDTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .thr      (thr),
    .idx_a    (idx_a),
    .pop_a    (pop_a),
    .idx_b    (idx_b),
    .pop_b    (pop_b),
    .push_en  (push_en),
    .push_idx (push_idx),
    .push_data(push_data),
    .flag_clr (flag_clr),
    .top_a    (top_a),
    .top_b    (top_b),
    .uflow    (uflow),
    .oflow    (oflow)
);

// File: tb/sim_osf_operand_file.sv
module sim_osf_operand_file;

    localparam int NT = 8;
    localparam int NS = 8;
    localparam int D  = 4;
    localparam int W  = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    thr = '0, idx_a = '0, idx_b = '0, push_idx = '0;
    logic          pop_a = 1'b0, pop_b = 1'b0, push_en = 1'b0, flag_clr = 1'b0;
    logic [W-1:0]  push_data = '0;
    logic [W-1:0]  top_a, top_b;
    logic [NS-1:0] uflow, oflow;

    always #5 clk = ~clk;

    osf_operand_file #(.NTHREADS(NT), .NSTACKS(NS), .DEPTH(D), .WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .thr(thr), .idx_a(idx_a), .pop_a(pop_a),
        .idx_b(idx_b), .pop_b(pop_b), .push_en(push_en), .push_idx(push_idx),
        .push_data(push_data), .flag_clr(flag_clr), .top_a(top_a), .top_b(top_b),
        .uflow(uflow), .oflow(oflow)
    );

    // Reference model of the stacks.
    logic [W-1:0] m [NT][NS][D];
    int           cnt [NT][NS];
    logic [7:0]   muf [NT];
    logic [7:0]   mof [NT];

    // Scoreboard queue: {top_a, top_b, uflow, oflow} plus requirement tag.
    logic [2*W+15:0] q_exp [$];
    string           q_req [$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic logic [W-1:0] mtop(int t, int s);
        return (cnt[t][s] == 0) ? '0 : m[t][s][cnt[t][s]-1];
    endfunction

    task automatic step(input int t, input int ia, input bit pa, input int ib,
                        input bit pb, input bit pe, input int pi,
                        input logic [W-1:0] pd, input bit cl, input string req);
        logic [7:0] pm;
        @(negedge clk);
        thr = 3'(t); idx_a = 3'(ia); pop_a = pa; idx_b = 3'(ib); pop_b = pb;
        push_en = pe; push_idx = 3'(pi); push_data = pd; flag_clr = cl;
        q_exp.push_back({mtop(t, ia), mtop(t, ib), muf[t], mof[t]});
        q_req.push_back(req);
        @(posedge clk);
        pm = '0;
        if (pa) pm[ia] = 1'b1;
        if (pb) pm[ib] = 1'b1;
        if (cl) begin muf[t] = '0; mof[t] = '0; end
        for (int s = 0; s < NS; s++) begin
            bit po = pm[s];
            bit pu = pe && (pi == s);
            int c  = cnt[t][s];
            if (po && pu) begin
                if (c == 0) begin muf[t][s] = 1'b1; m[t][s][0] = pd; cnt[t][s] = 1; end
                else m[t][s][c-1] = pd;
            end else if (po) begin
                if (c == 0) muf[t][s] = 1'b1;
                else cnt[t][s] = c - 1;
            end else if (pu) begin
                if (c == D) mof[t][s] = 1'b1;
                else begin m[t][s][c] = pd; cnt[t][s] = c + 1; end
            end
        end
    endtask

    task automatic look(input int t, input int ia, input int ib, input string req);
        step(t, ia, 0, ib, 0, 0, 0, '0, 0, req);
    endtask

    // Monitor: compares each expected item against the outputs.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q_exp.size() > 0) begin
                logic [2*W+15:0] e;
                string r;
                e = q_exp.pop_front();
                r = q_req.pop_front();
                checks++;
                if ({top_a, top_b, uflow, oflow} !== e) begin
                    errors++;
                    $display("FAIL %s: got a=%h b=%h uf=%b of=%b exp a=%h b=%h uf=%b of=%b",
                             r, top_a, top_b, uflow, oflow,
                             e[2*W+15:W+16], e[W+15:16], e[15:8], e[7:0]);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < NT; t++) begin
            muf[t] = '0; mof[t] = '0;
            for (int s = 0; s < NS; s++) cnt[t][s] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: everything empty and clear after reset
        look(0, 0, 1, "R11");
        look(3, 7, 7, "R11");

        // R5: pushes become the top
        step(0, 2, 0, 2, 0, 1, 2, 32'hA1, 0, "R5");
        step(0, 2, 0, 3, 0, 1, 2, 32'hB2, 0, "R5");
        // R3: non-popping reads keep the stack
        look(0, 2, 2, "R3");
        look(0, 2, 2, "R3");
        // R4: pop exposes the entry below
        step(0, 2, 1, 5, 0, 0, 0, '0, 0, "R4");
        look(0, 2, 5, "R4");

        // R1: thread isolation
        step(5, 2, 0, 2, 0, 1, 2, 32'hC3, 0, "R1");
        look(0, 2, 2, "R1");
        look(5, 2, 0, "R1");

        // R7: overflow on full stack
        for (int k = 0; k < 5; k++) step(1, 4, 0, 0, 0, 1, 4, 32'h10 + k, 0, "R7");
        look(1, 4, 4, "R7");

        // R8: replace on a full stack keeps depth, no new overflow
        step(1, 4, 1, 4, 0, 1, 4, 32'hEE, 0, "R8");
        look(1, 4, 0, "R8");
        // R10: clear then flags read zero
        step(1, 0, 0, 0, 0, 0, 0, '0, 1, "R10");
        look(1, 4, 4, "R10");
        for (int k = 0; k < 5; k++) step(1, 4, 1, 3, 0, 0, 0, '0, 0, "R8");
        look(1, 4, 4, "R6");

        // R6: pop of empty stack
        step(2, 6, 1, 6, 0, 0, 0, '0, 0, "R6");
        look(2, 6, 6, "R6");

        // R9: double pop on one stack removes one entry
        for (int k = 1; k <= 3; k++) step(3, 1, 0, 1, 0, 1, 1, 32'(k), 0, "R9");
        step(3, 1, 1, 1, 1, 0, 0, '0, 0, "R9");
        look(3, 1, 1, "R9");

        // R8: replace on empty stack
        step(4, 0, 1, 0, 0, 1, 0, 32'h55, 0, "R8");
        look(4, 0, 0, "R8");

        // R10: flags stay over unrelated activity; fault beats clear
        step(4, 3, 0, 0, 0, 1, 3, 32'h77, 0, "R10");
        look(4, 3, 0, "R10");
        step(2, 6, 1, 0, 0, 0, 0, '0, 1, "R10");
        look(2, 6, 0, "R10");

        // R2: two different stacks read at once
        step(6, 0, 0, 0, 0, 1, 7, 32'hDEAD0007, 0, "R2");
        step(6, 7, 0, 0, 0, 1, 0, 32'hBEEF0000, 0, "R2");
        look(6, 7, 0, "R2");
        look(6, 0, 7, "R2");

        // R2: randomized mix with legal values
        for (int k = 0; k < 400; k++) begin
            int r = $urandom;
            step(r[2:0], r[5:3], r[8:7] == 0, r[11:9], r[14:13] == 0,
                 r[16:15] != 0, r[19:17], $urandom, r[27:22] == 0, "R2");
        end
        look(0, 0, 0, "R2");

        repeat (2) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule